// File: doc/BRIEF.md
# Security-Banked Control Register File

This block holds a set of 32-bit configuration registers behind a single coprocessor-style access port. Each access carries a register index, read and write strobes, write data, a non-secure state bit (`acc_ns`) and a monitor-mode flag (`acc_mon`). Every register has a security class that is fixed by its index. A secure-only register can be reached only from the secure world. A banked register holds one secure copy and one non-secure copy. A common register is a single store that both worlds share.

For each access the block works out two things. The first is the world used for the permission check: the access is secure when monitor mode is active or when `acc_ns` is 0. The second is the copy of a banked register that is addressed, which always follows `acc_ns`. Accesses that are not allowed are dropped. A non-secure access to a secure-only register, and any access to an index with no register behind it, are both blocked. A blocked access raises `acc_fault` for one cycle.

A small sequencer tracks the response phase. The state is ST_IDLE when there is nothing to report. It moves to ST_DATA when a permitted read was taken, and to ST_FAULT when a blocked access was seen. The next state depends only on the current access. A blocked access, read or write, goes to ST_FAULT. Otherwise a read goes to ST_DATA. Otherwise the next state is ST_IDLE. These transitions apply from every state. `acc_fault` is high only in ST_FAULT.

Top module: `sec_bank_regfile`

## Requirements
- R1: A permitted write stores all 32 bits of `acc_wdata`, and a later permitted read of the same copy returns them unchanged.
- R2: After reset, the secure copy (or the only copy) of register i reads 0xC0DE0000 + i, and the non-secure copy of a banked register i reads 0xC0DE0100 + i.
- R3: The class is set by the index. Indices 0 to 11 are implemented. Among them, i mod 4 = 0 is common, i mod 4 = 2 is secure-only, and i mod 4 = 1 or 3 is banked. Indices 12 to 15 are unimplemented.
- R4: Outside monitor mode, `acc_ns` = 0 makes the access secure and addresses the secure copy of a banked register. `acc_ns` = 1 makes the access non-secure and addresses the non-secure copy.
- R5: In monitor mode every access counts as secure and never faults on an implemented index. A banked access addresses the secure copy when `acc_ns` = 0 and the non-secure copy when `acc_ns` = 1.
- R6: In monitor mode a secure-only register can be read and written with either value of `acc_ns`.
- R7: A non-secure access outside monitor mode to a secure-only register raises `acc_fault` in the cycle after the strobe. A blocked write leaves the register unchanged, and a blocked read returns zero.
- R8: A common register is one store: a write from either world is seen by a later read from the other world.
- R9: An access to an unimplemented index raises `acc_fault` in the cycle after the strobe, changes no register, and a read returns zero.
- R10: A write takes effect at the clock edge where the strobe is sampled. `rd_data` is updated one cycle after a read strobe and holds its value while no read is made. `acc_fault` is low after any cycle that has no blocked access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_idx | input | 4 | Register index |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 32 | Write data |
| acc_ns | input | 1 | Non-secure state bit; selects the banked copy |
| acc_mon | input | 1 | Monitor mode active |
| rd_data | output | 32 | Registered read data |
| acc_fault | output | 1 | One-cycle access-fault pulse |

## Verification
The assertions watch the permission rules on every cycle. A blocked or unimplemented access must be followed by a fault and, for a read, by zero data. A monitor-mode access to an implemented index, or a cycle with no access, must never be followed by a fault. `rd_data` must not change while no read is made. What the assertions cannot show is which copy an access actually reaches. Bank selection, sharing of common registers, reset contents and the absence of side effects from blocked writes become visible only through the bench's write-then-read scenarios across the two worlds.

// File: rtl/sec_bank_regfile_pkg.sv
package sec_bank_regfile_pkg;

    typedef enum logic [1:0] {
        CLS_COMMON = 2'd0,
        CLS_BANKED = 2'd1,
        CLS_SECURE = 2'd2,
        CLS_NONE   = 2'd3
    } reg_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_FAULT = 2'd2
    } resp_state_e;

    // Security class of a register index (R3)
    function automatic reg_class_e class_of(input int unsigned idx, input int unsigned n_impl);
        if (idx >= n_impl) return CLS_NONE;
        case (idx % 4)
            0:       return CLS_COMMON;
            2:       return CLS_SECURE;
            default: return CLS_BANKED;
        endcase
    endfunction

    // Reset constant of one register copy (R2)
    function automatic logic [31:0] reset_of(input int unsigned idx, input logic ns_copy);
        return 32'hC0DE_0000 | {23'd0, ns_copy, idx[7:0]};
    endfunction

endpackage

// File: rtl/sec_bank_access_decode.sv
module sec_bank_access_decode
    import sec_bank_regfile_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int NUM_IMPL = 12
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             ns,
    input  logic             mon,
    input  logic             rd,
    input  logic             wr,
    output logic             access,
    output logic             legal,
    output logic             sel_ns
);
    reg_class_e cls;
    logic       eff_secure;

    always_comb begin
        cls        = class_of(32'(idx), NUM_IMPL);
        // Monitor mode forces the secure world for permission checks
        eff_secure = mon | ~ns;
        access     = rd | wr;
        legal      = (cls != CLS_NONE) && !((cls == CLS_SECURE) && !eff_secure);
        // Banked copy always follows the NS bit
        sel_ns     = ns && (cls == CLS_BANKED);
    end

endmodule

// File: rtl/sec_bank_reg_store.sv
module sec_bank_reg_store
    import sec_bank_regfile_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int NUM_IMPL = 12,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              sel_ns,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sec_view [NUM_IMPL];
    logic [DATA_W-1:0] ns_view  [NUM_IMPL];

    for (genvar i = 0; i < NUM_IMPL; i++) begin : g_reg
        localparam reg_class_e CLS = class_of(i, NUM_IMPL);
        logic [DATA_W-1:0] sec_q;
        logic              hit;

        assign hit = wr_en && (idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sec_q <= DATA_W'(reset_of(i, 1'b0));
            else if (hit && !sel_ns)
                sec_q <= wdata;
        end
        assign sec_view[i] = sec_q;

        if (CLS == CLS_BANKED) begin : g_banked
            logic [DATA_W-1:0] ns_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ns_q <= DATA_W'(reset_of(i, 1'b1));
                else if (hit && sel_ns)
                    ns_q <= wdata;
            end
            assign ns_view[i] = ns_q;
        end else begin : g_single
            assign ns_view[i] = sec_q;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_IMPL; i++) begin
            if (idx == IDX_W'(i))
                rdata = sel_ns ? ns_view[i] : sec_view[i];
        end
    end

endmodule

// File: rtl/sec_bank_regfile.sv
module sec_bank_regfile
    import sec_bank_regfile_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int NUM_IMPL = 12,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_ns,
    input  logic              acc_mon,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_fault
);
    logic              access;
    logic              legal;
    logic              sel_ns;
    logic [DATA_W-1:0] store_rdata;
    logic [DATA_W-1:0] rd_data_q;
    resp_state_e       state_q, state_d;

    sec_bank_access_decode #(
        .IDX_W    (IDX_W),
        .NUM_IMPL (NUM_IMPL)
    ) u_decode (
        .idx    (acc_idx),
        .ns     (acc_ns),
        .mon    (acc_mon),
        .rd     (acc_rd),
        .wr     (acc_wr),
        .access (access),
        .legal  (legal),
        .sel_ns (sel_ns)
    );

    sec_bank_reg_store #(
        .IDX_W    (IDX_W),
        .NUM_IMPL (NUM_IMPL),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc_wr && legal),
        .idx    (acc_idx),
        .sel_ns (sel_ns),
        .wdata  (acc_wdata),
        .rdata  (store_rdata)
    );

    // Next-state choice depends only on the current access
    always_comb begin
        if (access && !legal)
            state_d = ST_FAULT;
        else if (acc_rd)
            state_d = ST_DATA;
        else
            state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Read data capture: zero for a blocked read, hold when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data_q <= '0;
        else if (acc_rd)
            rd_data_q <= legal ? store_rdata : '0;
    end

    // Outputs
    always_comb begin
        rd_data = rd_data_q;
        unique case (state_q)
            ST_FAULT: acc_fault = 1'b1;
            ST_DATA:  acc_fault = 1'b0;
            default:  acc_fault = 1'b0;
        endcase
    end

endmodule

// File: rtl/sec_bank_regfile_chk.sv
module sec_bank_regfile_chk
    import sec_bank_regfile_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int NUM_IMPL = 12,
    parameter int DATA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  acc_idx,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              acc_ns,
    input logic              acc_mon,
    input logic [DATA_W-1:0] rd_data,
    input logic              acc_fault
);
    logic       any_acc;
    reg_class_e cls;

    always_comb begin
        any_acc = acc_rd | acc_wr;
        cls     = class_of(32'(acc_idx), NUM_IMPL);
    end

    a_r7_nonsec_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && !acc_mon && acc_ns && cls == CLS_SECURE) |=> acc_fault);

    a_r7_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_mon && acc_ns && cls == CLS_SECURE) |=> (rd_data == '0));

    a_r9_unimpl_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && cls == CLS_NONE) |=> acc_fault);

    a_r9_unimpl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && cls == CLS_NONE) |=> (rd_data == '0));

    a_r5_monitor_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mon && cls != CLS_NONE) |=> !acc_fault);

    a_r10_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !any_acc |=> !acc_fault);

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(rd_data));

endmodule

bind sec_bank_regfile sec_bank_regfile_chk #(
    .IDX_W    (IDX_W),
    .NUM_IMPL (NUM_IMPL),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_idx   (acc_idx),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_ns    (acc_ns),
    .acc_mon   (acc_mon),
    .rd_data   (rd_data),
    .acc_fault (acc_fault)
);

// File: tb/sec_bank_regfile_test.sv
module sec_bank_regfile_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  acc_idx = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ns = 1'b0;
    logic        acc_mon = 1'b0;
    logic [31:0] rd_data;
    logic        acc_fault;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the register copies
    logic [31:0] m_sec [12];
    logic [31:0] m_nsb [12];

    always #10 clk = ~clk;  // 50 MHz

    sec_bank_regfile uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_idx   (acc_idx),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_wdata (acc_wdata),
        .acc_ns    (acc_ns),
        .acc_mon   (acc_mon),
        .rd_data   (rd_data),
        .acc_fault (acc_fault)
    );

    function automatic int cls_of(input int i);  // 0 common 1 banked 2 secure 3 none
        if (i >= 12) return 3;
        if (i % 4 == 0) return 0;
        if (i % 4 == 2) return 2;
        return 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input int idx, input logic ns, input logic mon,
                         input logic [31:0] d, input logic exp_fault, input string tag);
        @(negedge clk);
        acc_idx = 4'(idx); acc_ns = ns; acc_mon = mon; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
        check({tag, " fault"}, {31'd0, acc_fault}, {31'd0, exp_fault});
        if (!exp_fault) begin
            if (cls_of(idx) == 1 && ns) m_nsb[idx] = d;
            else                        m_sec[idx] = d;
        end
    endtask

    task automatic do_rd(input int idx, input logic ns, input logic mon,
                         input logic [31:0] exp, input logic exp_fault, input string tag);
        @(negedge clk);
        acc_idx = 4'(idx); acc_ns = ns; acc_mon = mon; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        check({tag, " data"}, rd_data, exp);
        check({tag, " fault"}, {31'd0, acc_fault}, {31'd0, exp_fault});
    endtask

    function automatic logic [31:0] rv(input int i, input logic nsc);
        return 32'hC0DE_0000 | (nsc ? 32'h100 : 32'h0) | 32'(i);
    endfunction

    task automatic t_reset;  // R2
        check("R2 fault after reset", {31'd0, acc_fault}, 32'd0);
        check("R2 rd_data after reset", rd_data, 32'd0);
        for (int i = 0; i < 12; i++) begin
            m_sec[i] = rv(i, 1'b0);
            m_nsb[i] = rv(i, 1'b1);
            do_rd(i, 1'b0, 1'b0, rv(i, 1'b0), 1'b0, "R2 secure reset");
            if (cls_of(i) == 1)
                do_rd(i, 1'b1, 1'b0, rv(i, 1'b1), 1'b0, "R2 non-secure reset");
        end
    endtask

    task automatic t_class_map;  // R3
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            int c;
            c = cls_of(i);
            e = (c >= 2) ? 32'd0 : (c == 1 ? m_nsb[i] : m_sec[i]);
            do_rd(i, 1'b1, 1'b0, e, logic'(c >= 2), "R3 class map");
        end
    endtask

    task automatic t_full_width;  // R1
        do_wr(0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, "R1 write ones");
        do_rd(0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, "R1 read ones");
        do_wr(0, 1'b0, 1'b0, 32'hA5A5_5A5A, 1'b0, "R1 write pattern");
        do_rd(0, 1'b0, 1'b0, 32'hA5A5_5A5A, 1'b0, "R1 read pattern");
    endtask

    task automatic t_banked_normal;  // R4
        do_wr(1, 1'b0, 1'b0, 32'h1111_0001, 1'b0, "R4 secure write");
        do_wr(1, 1'b1, 1'b0, 32'h2222_0001, 1'b0, "R4 non-secure write");
        do_rd(1, 1'b0, 1'b0, 32'h1111_0001, 1'b0, "R4 secure copy");
        do_rd(1, 1'b1, 1'b0, 32'h2222_0001, 1'b0, "R4 non-secure copy");
    endtask

    task automatic t_banked_monitor;  // R5
        do_wr(5, 1'b1, 1'b1, 32'h3333_0005, 1'b0, "R5 mon ns=1 write");
        do_rd(5, 1'b0, 1'b1, m_sec[5], 1'b0, "R5 mon ns=0 secure copy");
        do_rd(5, 1'b1, 1'b0, 32'h3333_0005, 1'b0, "R5 non-secure copy updated");
        do_wr(7, 1'b0, 1'b1, 32'h4444_0007, 1'b0, "R5 mon ns=0 write");
        do_rd(7, 1'b1, 1'b1, m_nsb[7], 1'b0, "R5 mon ns=1 non-secure copy");
        do_rd(7, 1'b0, 1'b0, 32'h4444_0007, 1'b0, "R5 secure copy updated");
    endtask

    task automatic t_secure_monitor;  // R6
        do_wr(2, 1'b1, 1'b1, 32'h5555_0002, 1'b0, "R6 mon ns=1 write secure-only");
        do_rd(2, 1'b0, 1'b1, 32'h5555_0002, 1'b0, "R6 mon ns=0 read");
        do_rd(2, 1'b1, 1'b1, 32'h5555_0002, 1'b0, "R6 mon ns=1 read");
    endtask

    task automatic t_blocked;  // R7
        do_wr(6, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b1, "R7 blocked write");
        do_rd(6, 1'b0, 1'b0, m_sec[6], 1'b0, "R7 register unchanged");
        do_rd(6, 1'b1, 1'b0, 32'd0, 1'b1, "R7 blocked read");
    endtask

    task automatic t_common;  // R8
        do_wr(4, 1'b1, 1'b0, 32'h6666_0004, 1'b0, "R8 non-secure write");
        do_rd(4, 1'b0, 1'b0, 32'h6666_0004, 1'b0, "R8 secure sees it");
        do_wr(8, 1'b0, 1'b0, 32'h7777_0008, 1'b0, "R8 secure write");
        do_rd(8, 1'b1, 1'b0, 32'h7777_0008, 1'b0, "R8 non-secure sees it");
    endtask

    task automatic t_unimpl;  // R9
        do_wr(13, 1'b0, 1'b1, 32'hBAD0_000D, 1'b1, "R9 unimplemented write");
        do_rd(13, 1'b0, 1'b1, 32'd0, 1'b1, "R9 unimplemented read");
        for (int i = 0; i < 12; i++)
            do_rd(i, 1'b0, 1'b1, m_sec[i], 1'b0, "R9 no state changed");
    endtask

    task automatic t_timing;  // R10
        do_rd(9, 1'b1, 1'b0, m_nsb[9], 1'b0, "R10 read latency");
        @(negedge clk);
        check("R10 rd_data held", rd_data, m_nsb[9]);
        do_rd(14, 1'b0, 1'b0, 32'd0, 1'b1, "R10 fault source");
        @(negedge clk);
        check("R10 fault one cycle", {31'd0, acc_fault}, 32'd0);
        @(negedge clk);
        acc_idx = 4'd3; acc_ns = 1'b0; acc_mon = 1'b0; acc_wdata = 32'h0BAD_F00D; acc_wr = 1'b1;
        acc_rd = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
        check("R10 read with write sees old value", rd_data, m_sec[3]);
        m_sec[3] = 32'h0BAD_F00D;
        do_rd(3, 1'b0, 1'b0, 32'h0BAD_F00D, 1'b0, "R10 write took effect at edge");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_class_map();
        t_full_width();
        t_banked_normal();
        t_banked_monitor();
        t_secure_monitor();
        t_blocked();
        t_common();
        t_unimpl();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule